// File: doc/BRIEF.md
# S/PDIF Input Sample-Rate Mode Detector

This block watches a biphase-mark serial audio line that is sampled in a fast reference clock domain and works out which of seven standard sample rates the line carries. The line first passes through a two-stage synchronizer. Every level change then counts as an edge, and the block counts the clock cycles between consecutive edges. Over a measurement window of programmable length it keeps the shortest interval it has seen. In biphase-mark coding the shortest interval is half a bit cell, so it is inversely proportional to the sample rate.

At the end of each window the block doubles the shortest interval and compares it against a ladder of six programmable thresholds. Software fills each threshold with the sum of two neighbouring nominal mode timers. The first threshold that the doubled width reaches, scanning from the slowest rate upward, gives the mode code: 0 to 6 stand for 32000, 44100, 48000, 88200, 96000, 176400 and 192000 Hz. Code 6 is also the fallback when no threshold is reached. A window that closes no interval reports code 7 (no signal) with width 0.

Thresholds and nominal timers are supplied as packed 32-bit configuration words, and the block unpacks them itself. When the reported mode changes, an interrupt pulse is raised if the mask allows it.

Top module: `spdr_rate_sense`

## Requirements
- R1: While reset is asserted and until the first window ends, mode_o is 7 and width_o, mode_timer_o and irq_o are 0.
- R2: The line passes two synchronizer flops, and every level change of the synchronized line is an edge. An interval is the number of clock cycles between two consecutive edges. It saturates at 1023, and an interval that spans a window boundary belongs to the window in which it closes.
- R3: A window lasts win_len_i clock cycles, with 0 treated as 1. The outputs change only on the clock edge that follows the last cycle of a window.
- R4: width_o is the smallest interval that closed during the window just ended, including an interval closing in that window's last cycle. The running minimum restarts at all ones for every window.
- R5: mode_o is the lowest i in 0..5 for which twice the width is greater than or equal to threshold i. When no such i exists, mode_o is 6.
- R6: A window in which no interval closed reports mode_o = 7 and width_o = 0.
- R7: Threshold i (10 bits) sits in word i/3 of thr_cfg_i, at bit offset 10*(2 - i mod 3) within that word. Word k occupies bits 32k+31 down to 32k.
- R8: Timer slot i (8 bits, i = 0..7) sits in word i/4 of tmr_cfg_i, at bit offset 8*(3 - i mod 4). mode_timer_o shows the slot selected by the reported mode, and slot 7 is used for no signal.
- R9: irq_o pulses for one cycle, together with the output update, when the new mode differs from the previous reported mode (including changes into and out of 7) and irq_mask_i bit 2 is set. The other mask bits have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Asynchronous biphase-mark input line |
| win_len_i | input | 20 | Measurement window length in clock cycles |
| tmr_cfg_i | input | 64 | Two packed words of nominal 8-bit mode timers |
| thr_cfg_i | input | 64 | Two packed words of 10-bit mode thresholds |
| irq_mask_i | input | 8 | Interrupt mask; bit 2 enables mode-change interrupts |
| mode_o | output | 3 | Detected mode, 7 for no signal |
| width_o | output | 10 | Minimum interval of the last window |
| mode_timer_o | output | 8 | Nominal timer slot of the reported mode |
| irq_o | output | 1 | Mode-change interrupt pulse |

## Verification
The delicate coincidence is an edge that closes an interval in the very cycle in which the window ends. That interval must still count toward the window that is closing, and the running minimum must then restart cleanly. The bench provokes this by making the window length equal to the half-cell period of the stream, and also by using one-cycle windows, so edges and window ends keep landing in the same cycle. A behavioural model, built on cycle timestamps of edges, predicts every output, and the design's outputs are compared against it on every clock.

// File: rtl/spdr_pkg.sv
package spdr_pkg;
    localparam int MODE_N       = 7;
    localparam int MODE_W       = 3;
    localparam int WORD_W       = 32;
    localparam int TMR_W        = 8;
    localparam int THR_W        = 10;
    localparam int TMR_PER      = WORD_W / TMR_W;
    localparam int THR_PER      = WORD_W / THR_W;
    localparam int TMR_SLOTS    = MODE_N + 1;
    localparam int THR_N        = MODE_N - 1;
    localparam int TMR_WORDS    = (TMR_SLOTS + TMR_PER - 1) / TMR_PER;
    localparam int THR_WORDS    = (THR_N + THR_PER - 1) / THR_PER;
    localparam int IRQ_W        = 8;
    localparam int IRQ_MODE_BIT = 2;

    typedef logic [MODE_W-1:0] mode_t;
    localparam mode_t MODE_NONE = mode_t'(MODE_N);
endpackage

// File: rtl/spdr_cfg_unpack.sv
module spdr_cfg_unpack
    import spdr_pkg::*;
(
    input  logic [TMR_WORDS*WORD_W-1:0] tmr_cfg_i,
    input  logic [THR_WORDS*WORD_W-1:0] thr_cfg_i,
    output logic [TMR_SLOTS-1:0][TMR_W-1:0] tmr_o,
    output logic [THR_N-1:0][THR_W-1:0]     thr_o
);
    // Lower-numbered slots live in higher bit positions of each word.
    for (genvar gi = 0; gi < TMR_SLOTS; gi++) begin : g_tmr
        localparam int WORD  = gi / TMR_PER;
        localparam int SHIFT = TMR_W * (TMR_PER - 1 - (gi % TMR_PER));
        assign tmr_o[gi] = tmr_cfg_i[WORD*WORD_W + SHIFT +: TMR_W];
    end

    for (genvar gi = 0; gi < THR_N; gi++) begin : g_thr
        localparam int WORD  = gi / THR_PER;
        localparam int SHIFT = THR_W * (THR_PER - 1 - (gi % THR_PER));
        assign thr_o[gi] = thr_cfg_i[WORD*WORD_W + SHIFT +: THR_W];
    end
endmodule

// File: rtl/spdr_window_timer.sv
module spdr_window_timer #(
    parameter int WIN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIN_W-1:0] len_i,
    output logic             end_o
);
    typedef struct packed {
        logic [WIN_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [WIN_W-1:0] last_idx;

    always_comb begin
        st_d     = st_q;
        last_idx = (len_i == '0) ? '0 : len_i - 1'b1;
        end_o    = (st_q.cnt >= last_idx);
        if (end_o) st_d.cnt = '0;
        else       st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_window_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        end_o |=> (st_q.cnt == '0));
endmodule

// File: rtl/spdr_edge_meter.sv
module spdr_edge_meter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] min_o,
    output logic             got_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             s3;
        logic             have_prev;
        logic             got;
        logic [CNT_W-1:0] run;
        logic [CNT_W-1:0] minw;
    } st_t;

    st_t st_d, st_q;
    logic edge_seen, cand_vld;

    always_comb begin
        st_d      = st_q;
        edge_seen = st_q.s2 ^ st_q.s3;
        cand_vld  = edge_seen && st_q.have_prev;

        // Result including an interval closing in this very cycle.
        min_o = (cand_vld && (st_q.run < st_q.minw)) ? st_q.run : st_q.minw;
        got_o = st_q.got || cand_vld;

        st_d.s1 = line_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        st_d.have_prev = st_q.have_prev || edge_seen;

        if (edge_seen)                st_d.run = {{(CNT_W-1){1'b0}}, 1'b1};
        else if (st_q.run != CNT_MAX) st_d.run = st_q.run + 1'b1;

        if (clear_i) begin
            st_d.minw = CNT_MAX;
            st_d.got  = 1'b0;
        end else begin
            st_d.minw = min_o;
            st_d.got  = got_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.minw <= CNT_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    assert_min_monotone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (st_q.minw <= $past(st_q.minw)));
    assert_interval_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.have_prev |-> (st_q.run != '0));
endmodule

// File: rtl/spdr_classifier.sv
module spdr_classifier
    import spdr_pkg::*;
(
    input  logic [THR_W-1:0]                min_i,
    input  logic                            got_i,
    input  logic [THR_N-1:0][THR_W-1:0]     thr_i,
    input  logic [TMR_SLOTS-1:0][TMR_W-1:0] tmr_i,
    output mode_t                           mode_o,
    output logic [THR_W-1:0]                width_o,
    output logic [TMR_W-1:0]                tmr_o
);
    logic [THR_W:0] dbl;

    always_comb begin
        dbl    = {min_i, 1'b0};
        mode_o = mode_t'(MODE_N - 1);
        // Scan fastest-to-slowest so the lowest matching index wins.
        for (int i = THR_N - 1; i >= 0; i--) begin
            if (dbl >= {1'b0, thr_i[i]}) mode_o = mode_t'(i);
        end
        width_o = min_i;
        if (!got_i) begin
            mode_o  = MODE_NONE;
            width_o = '0;
        end
        tmr_o = tmr_i[mode_o];
    end
endmodule

// File: rtl/spdr_rate_sense.sv
module spdr_rate_sense
    import spdr_pkg::*;
#(
    parameter int WIN_W = 20
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        line_i,
    input  logic [WIN_W-1:0]            win_len_i,
    input  logic [TMR_WORDS*WORD_W-1:0] tmr_cfg_i,
    input  logic [THR_WORDS*WORD_W-1:0] thr_cfg_i,
    input  logic [IRQ_W-1:0]            irq_mask_i,
    output logic [MODE_W-1:0]           mode_o,
    output logic [THR_W-1:0]            width_o,
    output logic [TMR_W-1:0]            mode_timer_o,
    output logic                        irq_o
);
    typedef struct packed {
        mode_t            mode;
        logic [THR_W-1:0] width;
        logic [TMR_W-1:0] tmr;
        logic             irq;
    } out_t;

    out_t out_d, out_q;

    logic                            win_end;
    logic [THR_W-1:0]                meas_min;
    logic                            meas_got;
    logic [TMR_SLOTS-1:0][TMR_W-1:0] tmr_arr;
    logic [THR_N-1:0][THR_W-1:0]     thr_arr;
    mode_t                           cls_mode;
    logic [THR_W-1:0]                cls_width;
    logic [TMR_W-1:0]                cls_tmr;
    logic [IRQ_W-1:0]                flags;

    spdr_window_timer #(.WIN_W(WIN_W)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .len_i (win_len_i),
        .end_o (win_end)
    );

    spdr_edge_meter #(.CNT_W(THR_W)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (line_i),
        .clear_i (win_end),
        .min_o   (meas_min),
        .got_o   (meas_got)
    );

    spdr_cfg_unpack u_cfg (
        .tmr_cfg_i (tmr_cfg_i),
        .thr_cfg_i (thr_cfg_i),
        .tmr_o     (tmr_arr),
        .thr_o     (thr_arr)
    );

    spdr_classifier u_cls (
        .min_i   (meas_min),
        .got_i   (meas_got),
        .thr_i   (thr_arr),
        .tmr_i   (tmr_arr),
        .mode_o  (cls_mode),
        .width_o (cls_width),
        .tmr_o   (cls_tmr)
    );

    always_comb begin
        out_d     = out_q;
        flags     = '0;
        out_d.irq = 1'b0;
        if (win_end) begin
            flags[IRQ_MODE_BIT] = (cls_mode != out_q.mode);
            out_d.mode  = cls_mode;
            out_d.width = cls_width;
            out_d.tmr   = cls_tmr;
            out_d.irq   = |(flags & irq_mask_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q      <= '0;
            out_q.mode <= MODE_NONE;
        end else begin
            out_q <= out_d;
        end
    end

    assign mode_o       = out_q.mode;
    assign width_o      = out_q.width;
    assign mode_timer_o = out_q.tmr;
    assign irq_o        = out_q.irq;

    assert_none_zero_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.mode == MODE_NONE) == (out_q.width == '0));
    assert_irq_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.irq |-> (out_q.mode != $past(out_q.mode)));
    assert_hold_midwindow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(win_end) |-> ($stable(out_q.mode) && $stable(out_q.width)));
    assert_timer_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(win_end) |-> (out_q.tmr == $past(tmr_arr[cls_mode])));
endmodule

// File: tb/tb_spdr_rate_sense.sv
module tb_spdr_rate_sense;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_i = 1'b0;
    logic [19:0] win_len_i = 20'd600;
    logic [63:0] tmr_cfg_i;
    logic [63:0] thr_cfg_i;
    logic [7:0]  irq_mask_i = 8'hFF;
    logic [2:0]  mode_o;
    logic [9:0]  width_o;
    logic [7:0]  mode_timer_o;
    logic        irq_o;

    int n_tests = 0, n_fail = 0, cyc = 0, irq_seen = 0;
    int tmr[8] = '{96, 70, 64, 35, 32, 17, 16, 0};
    int thr[6];

    always #5 clk = ~clk;

    spdr_rate_sense dut (.*);

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Packing per R7 and R8
    initial begin
        tmr_cfg_i = '0;
        thr_cfg_i = '0;
        for (int i = 0; i < 6; i++) thr[i] = tmr[i] + tmr[i+1];
        for (int i = 0; i < 8; i++)
            tmr_cfg_i[(i/4)*32 + 8*(3 - i%4) +: 8] = 8'(tmr[i]);
        for (int i = 0; i < 6; i++)
            thr_cfg_i[(i/3)*32 + 10*(2 - i%3) +: 10] = 10'(thr[i]);
    end

    // Behavioural reference model built on edge timestamps
    bit hist[$];
    int m_cyc, last_edge, wcnt, mw, iv, lim, nm;
    bit got, ed;
    int e_mode = 7, e_w = 0, e_t = 0, e_irq = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            hist = '{0, 0, 0};
            m_cyc = 0; last_edge = -1; wcnt = 0; mw = 1023; got = 0;
            e_mode = 7; e_w = 0; e_t = 0; e_irq = 0;
        end else begin
            m_cyc++;
            hist.push_back(line_i);
            ed = hist[hist.size()-3] ^ hist[hist.size()-4];
            if (ed) begin
                if (last_edge >= 0) begin
                    iv = m_cyc - last_edge;
                    if (iv > 1023) iv = 1023;
                    if (iv < mw) mw = iv;
                    got = 1;
                end
                last_edge = m_cyc;
            end
            lim = (win_len_i == 0) ? 1 : int'(win_len_i);
            e_irq = 0;
            if (wcnt >= lim - 1) begin
                if (!got) nm = 7;
                else begin
                    nm = 6;
                    for (int i = 5; i >= 0; i--) if (2*mw >= thr[i]) nm = i;
                end
                e_irq = (nm != e_mode) && irq_mask_i[2];
                e_mode = nm;
                e_w = got ? mw : 0;
                e_t = tmr[nm];
                mw = 1023; got = 0; wcnt = 0;
            end else wcnt++;
            if (hist.size() > 8) void'(hist.pop_front());
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 R5 mode", mode_o, e_mode);
            chk("R4 width", width_o, e_w);
            chk("R8 timer", mode_timer_o, e_t);
            chk("R9 irq", irq_o, e_irq);
            if (irq_o) irq_seen++;
        end
    end

    task automatic stream(input int h, input int ncyc);
        int left = h;
        int k = 0;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            left--;
            if (left <= 0) begin
                line_i = ~line_i;
                k = (k + 1) % 3;
                left = (k == 2) ? 2*h : h;
            end
        end
    endtask

    task automatic idle(input int ncyc);
        repeat (ncyc) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset mode", mode_o, 7);
        chk("R1 reset width", width_o, 0);
        chk("R1 reset timer", mode_timer_o, 0);
        chk("R1 reset irq", irq_o, 0);
        rst_n = 1'b1;
        idle(1300);
        chk("R6 idle mode", mode_o, 7);
        chk("R6 idle width", width_o, 0);
        stream(96, 1300);
        chk("R5 R7 mode0", mode_o, 0);
        chk("R4 width96", width_o, 96);
        stream(64, 1300);
        chk("R5 R7 mode2", mode_o, 2);
        stream(67, 1300);
        chk("R5 boundary equal mode1", mode_o, 1);
        stream(66, 1300);
        chk("R5 boundary below mode2", mode_o, 2);
        stream(33, 1300);
        chk("R5 mode4", mode_o, 4);
        chk("R8 timer slot4", mode_timer_o, 32);
        stream(16, 1300);
        chk("R5 fallback mode6", mode_o, 6);
        irq_mask_i = 8'hFB;
        irq_seen = 0;
        stream(96, 1300);
        chk("R9 masked mode0", mode_o, 0);
        chk("R9 masked irq count", irq_seen, 0);
        irq_mask_i = 8'h04;
        idle(1300);
        chk("R6 stopped mode", mode_o, 7);
        chk("R8 slot7 timer", mode_timer_o, 0);
        win_len_i = 20'd3000;
        stream(1500, 7000);
        chk("R2 saturated width", width_o, 1023);
        win_len_i = 20'd7;
        stream(7, 400);
        win_len_i = 20'd0;
        stream(1, 200);
        win_len_i = 20'd600;
        stream(35, 1300);
        chk("R5 mode3", mode_o, 3);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired (R3 R1) actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule